// File: doc/BRIEF.md
# Fractional-Period Time-of-Day Clock

This block keeps a hardware time-of-day made of a nanoseconds field and a 48-bit seconds count. The seconds are held as a 16-bit high word and a 32-bit low word. On every reference clock edge the time advances by a programmable period. The period is a whole number of nanoseconds plus a fraction, numerator over denominator. A fractional accumulator adds the numerator each cycle. When the sum reaches the denominator, the denominator is taken off and one extra nanosecond goes into that cycle's increment. A 2.5 ns period is therefore quotient 2 with numerator 5 and denominator 10.

Software controls the clock through a small register port. It writes the period, an absolute time and a signed phase step into staging registers. A separate strobe write applies each one, one cycle after the strobe. Reading the nanoseconds register freezes both seconds words in shadow copies, so a read of nanoseconds, then seconds-high, then seconds-low returns one coherent instant. The live seconds-high word is also driven on a port, so a receive path can complete a timestamp that carries only the low seconds.

Top module: `frac_tod_clock`

## Requirements
- R1: After reset the time is zero, the active and staged period is quotient 8, numerator 0, denominator 1, the invalid-period flag is clear and read data is zero.
- R2: Over any run of `den` consecutive cycles, with no load or step, nanoseconds advance by exactly `quo*den + num`. The one-nanosecond fractional carry is taken whenever accumulator plus numerator reaches the denominator.
- R3: Quotient (address 0), numerator (1) and denominator (2) are staged. A write to address 3 with bit 0 set makes all three active together one cycle later and clears the accumulator.
- R4: A commit whose staged denominator is zero, or whose numerator is not below the denominator, leaves the active period unchanged and sets `bad_period`. A later valid commit clears it.
- R5: Nanoseconds stay below 1,000,000,000 and wrap modulo that value. Each wrap adds one to the seconds, with the low word carrying into the high word.
- R6: Nanoseconds (address 6), seconds-high (7) and seconds-low (8) are staged. A write to address 9 with bit 0 set replaces the whole time one cycle later. A staged nanosecond value of one billion or more loads as 999,999,999.
- R7: The step word (address 4) holds a sign in bit 31 (1 = negative) and a magnitude in bits 29:0, clamped to 999,999,999. A write to address 5 with bit 0 set adds the step one cycle later, in the same cycle as that cycle's increment. The result borrows one second below zero and carries one or two seconds past the wrap.
- R8: A read of address 10 returns nanoseconds and captures both seconds words. Reads of address 11 (high) and 12 (low) return those captured values until the next nanoseconds read.
- R9: `sec_hi_now` always shows the live seconds-high word.
- R10: Each strobe acts exactly once. Time keeps advancing at the normal period in the cycles after a step or load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 4 | Register address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, registered one cycle after `rd_en` |
| bad_period | output | 1 | Last period commit was rejected |
| sec_hi_now | output | 16 | Live seconds-high word |

## Verification
A phase step is applied in the same cycle as the normal period increment. The two can also cross a second boundary together. Tests load a time just short of the wrap, or just past zero, and then strobe a step. Positive, negative, clamped and double-carry steps are each covered. The nanoseconds and the shadowed seconds read one cycle later must equal load value plus one period plus step, reduced modulo one billion with the matching seconds change. The read after that must show exactly one further period, which proves the strobe did not repeat.

// File: rtl/frac_tod_clock.sv
module frac_tod_clock #(
  parameter int QW = 8,
  parameter int FW = 32,
  parameter int SHW = 16,
  parameter int SLW = 32,
  parameter int NSW = 30,
  parameter int NS_PER_SEC = 1000000000,
  parameter int RST_QUO = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_en,
  input  logic           rd_en,
  input  logic [3:0]     addr,
  input  logic [31:0]    wdata,
  output logic [31:0]    rdata,
  output logic           bad_period,
  output logic [SHW-1:0] sec_hi_now
);
  localparam int SW = SHW + SLW;
  localparam int TW = NSW + 3;
  localparam logic [NSW-1:0] NS_MAX = NSW'(NS_PER_SEC - 1);
  localparam logic signed [TW-1:0] WRAP1 = TW'(64'(NS_PER_SEC));
  localparam logic signed [TW-1:0] WRAP2 = TW'(64'(NS_PER_SEC) * 2);

  localparam logic [3:0] A_QUO = 4'd0, A_NUM = 4'd1, A_DEN = 4'd2, A_PER_GO = 4'd3;
  localparam logic [3:0] A_STEP = 4'd4, A_STEP_GO = 4'd5;
  localparam logic [3:0] A_LD_NS = 4'd6, A_LD_SH = 4'd7, A_LD_SL = 4'd8, A_LD_GO = 4'd9;
  localparam logic [3:0] A_RD_NS = 4'd10, A_RD_SH = 4'd11, A_RD_SL = 4'd12;

  logic [QW-1:0]  stg_quo, quo_q;
  logic [FW-1:0]  stg_num, stg_den, num_q, den_q, acc_q;
  logic           step_neg;
  logic [29:0]    step_mag;
  logic [31:0]    ld_ns;
  logic [SHW-1:0] ld_sh, sh_shadow;
  logic [SLW-1:0] ld_sl, sl_shadow;
  logic [NSW-1:0] ns_q, ns_next;
  logic [SW-1:0]  sec_q, sec_next;
  logic           per_go, step_go, ld_go, bad_q;

  function automatic logic [NSW-1:0] clamp_ns(input logic [31:0] v);
    return (v >= 32'(NS_PER_SEC)) ? NS_MAX : v[NSW-1:0];
  endfunction

  wire [FW:0]   frac_sum   = {1'b0, acc_q} + {1'b0, num_q};
  wire          frac_carry = frac_sum >= {1'b0, den_q};
  wire [FW-1:0] acc_next   = FW'(frac_carry ? frac_sum - {1'b0, den_q} : frac_sum);
  wire          per_ok     = (stg_den != '0) && (stg_num < stg_den);
  wire [NSW-1:0] mag_c     = clamp_ns({2'b00, step_mag});

  logic signed [TW-1:0] step_delta, t_sum;

  always_comb begin
    step_delta = '0;
    if (step_go)
      step_delta = step_neg ? -$signed({3'b000, mag_c}) : $signed({3'b000, mag_c});
    t_sum = $signed({3'b000, ns_q}) + $signed(TW'(quo_q)) + $signed(TW'(frac_carry)) + step_delta;
    if (t_sum[TW-1]) begin
      ns_next  = NSW'(t_sum + WRAP1);
      sec_next = sec_q - SW'(1);
    end else if (t_sum >= WRAP2) begin
      ns_next  = NSW'(t_sum - WRAP2);
      sec_next = sec_q + SW'(2);
    end else if (t_sum >= WRAP1) begin
      ns_next  = NSW'(t_sum - WRAP1);
      sec_next = sec_q + SW'(1);
    end else begin
      ns_next  = NSW'(t_sum);
      sec_next = sec_q;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stg_quo <= QW'(RST_QUO); stg_num <= '0; stg_den <= FW'(1);
      quo_q <= QW'(RST_QUO);   num_q <= '0;   den_q <= FW'(1);
      acc_q <= '0;
      step_neg <= 1'b0; step_mag <= '0;
      ld_ns <= '0; ld_sh <= '0; ld_sl <= '0;
      ns_q <= '0; sec_q <= '0;
      sh_shadow <= '0; sl_shadow <= '0;
      per_go <= 1'b0; step_go <= 1'b0; ld_go <= 1'b0;
      bad_q <= 1'b0;
      rdata <= '0;
    end else begin
      per_go  <= wr_en && addr == A_PER_GO && wdata[0];
      step_go <= wr_en && addr == A_STEP_GO && wdata[0];
      ld_go   <= wr_en && addr == A_LD_GO && wdata[0];

      if (wr_en) begin
        case (addr)
          A_QUO:   stg_quo <= wdata[QW-1:0];
          A_NUM:   stg_num <= wdata[FW-1:0];
          A_DEN:   stg_den <= wdata[FW-1:0];
          A_STEP:  begin step_neg <= wdata[31]; step_mag <= wdata[29:0]; end
          A_LD_NS: ld_ns <= wdata;
          A_LD_SH: ld_sh <= wdata[SHW-1:0];
          A_LD_SL: ld_sl <= wdata[SLW-1:0];
          default: ;
        endcase
      end

      acc_q <= acc_next;
      if (per_go) begin
        if (per_ok) begin
          quo_q <= stg_quo; num_q <= stg_num; den_q <= stg_den;
          acc_q <= '0;
          bad_q <= 1'b0;
        end else begin
          bad_q <= 1'b1;
        end
      end

      if (ld_go) begin
        ns_q  <= clamp_ns(ld_ns);
        sec_q <= {ld_sh, ld_sl};
      end else begin
        ns_q  <= ns_next;
        sec_q <= sec_next;
      end

      if (rd_en) begin
        case (addr)
          A_RD_NS: begin
            rdata     <= 32'(ns_q);
            sh_shadow <= sec_q[SW-1:SLW];
            sl_shadow <= sec_q[SLW-1:0];
          end
          A_RD_SH: rdata <= 32'(sh_shadow);
          A_RD_SL: rdata <= 32'(sl_shadow);
          default: rdata <= '0;
        endcase
      end
    end
  end

  assign bad_period = bad_q;
  assign sec_hi_now = sec_q[SW-1:SLW];
endmodule

// File: rtl/frac_tod_clock_chk.sv
module frac_tod_clock_chk #(
  parameter int FW = 32,
  parameter int NSW = 30,
  parameter int SW = 48,
  parameter int SHW = 16,
  parameter int SLW = 32,
  parameter int NS_PER_SEC = 1000000000
) (
  input logic           clk,
  input logic           rst_n,
  input logic           rd_en,
  input logic [3:0]     addr,
  input logic [NSW-1:0] ns_q,
  input logic [SW-1:0]  sec_q,
  input logic [FW-1:0]  acc_q,
  input logic [FW-1:0]  den_q,
  input logic           per_go,
  input logic           step_go,
  input logic           ld_go,
  input logic [SHW-1:0] sh_shadow,
  input logic [SLW-1:0] sl_shadow
);
  a_r5_ns_below_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    32'(ns_q) < 32'(NS_PER_SEC));

  a_r2_acc_below_den: assert property (@(posedge clk) disable iff (!rst_n)
    acc_q < den_q);

  a_r4_den_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    den_q != '0);

  a_r10_step_oneshot: assert property (@(posedge clk) disable iff (!rst_n)
    step_go |=> !step_go);

  a_r10_load_oneshot: assert property (@(posedge clk) disable iff (!rst_n)
    ld_go |=> !ld_go);

  a_r10_period_oneshot: assert property (@(posedge clk) disable iff (!rst_n)
    per_go |=> !per_go);

  a_r8_shadow_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_en && addr == 4'd10) |=> ($stable(sh_shadow) && $stable(sl_shadow)));

  a_r5_sec_advance: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld_go && !step_go) |=> (sec_q == $past(sec_q) || sec_q == $past(sec_q) + SW'(1)));
endmodule

bind frac_tod_clock frac_tod_clock_chk #(
  .FW(FW), .NSW(NSW), .SW(SW), .SHW(SHW), .SLW(SLW), .NS_PER_SEC(NS_PER_SEC)
) u_chk (
  .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .addr(addr),
  .ns_q(ns_q), .sec_q(sec_q), .acc_q(acc_q), .den_q(den_q),
  .per_go(per_go), .step_go(step_go), .ld_go(ld_go),
  .sh_shadow(sh_shadow), .sl_shadow(sl_shadow)
);

// File: tb/sim_frac_tod_clock.sv
`timescale 1ns/1ps
module sim_frac_tod_clock;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        bad_period;
  logic [15:0] sec_hi_now;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  frac_tod_clock u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .bad_period(bad_period), .sec_hi_now(sec_hi_now)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0; wdata = '0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    d = rdata;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic load_time(input logic [31:0] ns, input logic [15:0] sh, input logic [31:0] sl);
    wr(4'd6, ns); wr(4'd7, 32'(sh)); wr(4'd8, sl);
    wr(4'd9, 32'd1);
  endtask

  task automatic set_period(input logic [31:0] q, input logic [31:0] n, input logic [31:0] d);
    wr(4'd0, q); wr(4'd1, n); wr(4'd2, d); wr(4'd3, 32'd1);
    idle(1);
  endtask

  task automatic t_reset;
    logic [31:0] v;
    check("R1 rdata after reset", 64'(rdata), 0);
    check("R1 bad_period after reset", 64'(bad_period), 0);
    check("R9 sec_hi after reset", 64'(sec_hi_now), 0);
    rd(4'd11, v);
    check("R1 seconds shadow after reset", 64'(v), 0);
  endtask

  task automatic t_default_period;
    logic [31:0] v;
    load_time(32'd1000, 16'h1234, 32'd5);
    idle(1);
    rd(4'd10, v); check("R6 loaded ns", 64'(v), 1000);
    rd(4'd10, v); check("R1 default 8 ns period", 64'(v), 1008);
    rd(4'd11, v); check("R6 loaded sec hi", 64'(v), 64'h1234);
    rd(4'd12, v); check("R6 loaded sec lo", 64'(v), 5);
    check("R9 live sec hi", 64'(sec_hi_now), 64'h1234);
  endtask

  task automatic t_wrap;
    logic [31:0] v;
    load_time(32'd999_999_992, 16'h0001, 32'hFFFF_FFFF);
    idle(1);
    rd(4'd10, v); check("R5 ns before wrap", 64'(v), 999_999_992);
    rd(4'd10, v); check("R5 ns wraps to zero", 64'(v), 0);
    rd(4'd11, v); check("R5 carry into sec hi", 64'(v), 2);
    rd(4'd12, v); check("R5 sec lo rolls to zero", 64'(v), 0);
    check("R9 live sec hi after carry", 64'(sec_hi_now), 2);
  endtask

  task automatic t_snapshot;
    logic [31:0] v;
    load_time(32'd999_999_900, 16'h0000, 32'd7);
    idle(1);
    rd(4'd10, v); check("R8 ns at snapshot", 64'(v), 999_999_900);
    idle(20);
    rd(4'd12, v); check("R8 shadow holds across wrap", 64'(v), 7);
    rd(4'd10, v);
    rd(4'd12, v); check("R8 shadow refreshed by ns read", 64'(v), 8);
  endtask

  task automatic t_fraction;
    logic [31:0] v;
    set_period(32'd2, 32'd5, 32'd10);
    load_time(32'd0, 16'h0, 32'd0);
    idle(1);
    rd(4'd10, v); check("R3 load before fraction run", 64'(v), 0);
    idle(9);
    rd(4'd10, v); check("R2 2.5 ns period over 10 cycles", 64'(v), 25);
  endtask

  task automatic t_bad_period;
    logic [31:0] v;
    set_period(32'd9, 32'd5, 32'd0);
    check("R4 zero denominator flagged", 64'(bad_period), 1);
    load_time(32'd100, 16'h0, 32'd0);
    idle(1);
    rd(4'd10, v);
    idle(9);
    rd(4'd10, v); check("R4 period kept after bad commit", 64'(v), 125);
    set_period(32'd9, 32'd10, 32'd10);
    check("R4 numerator not below denominator flagged", 64'(bad_period), 1);
    set_period(32'd4, 32'd0, 32'd1);
    check("R4 valid commit clears flag", 64'(bad_period), 0);
    load_time(32'd0, 16'h0, 32'd0);
    idle(1);
    rd(4'd10, v);
    rd(4'd10, v); check("R3 committed 4 ns period", 64'(v), 4);
  endtask

  task automatic t_step(input string tag, input logic [31:0] l_ns, input logic [15:0] sh,
                        input logic [31:0] sl, input logic [31:0] stepw,
                        input logic [31:0] exp_ns, input logic [15:0] exp_sh,
                        input logic [31:0] exp_sl);
    logic [31:0] v;
    wr(4'd4, stepw);
    load_time(l_ns, sh, sl);
    wr(4'd5, 32'd1);
    rd(4'd10, v); check({"R7 ", tag, " ns before step"}, 64'(v), 64'(l_ns));
    rd(4'd10, v); check({"R7 ", tag, " ns after step"}, 64'(v), 64'(exp_ns));
    rd(4'd11, v); check({"R7 ", tag, " sec hi after step"}, 64'(v), 64'(exp_sh));
    rd(4'd12, v); check({"R7 ", tag, " sec lo after step"}, 64'(v), 64'(exp_sl));
    idle(1);
    rd(4'd10, v);
    check({"R10 ", tag, " step not repeated"}, 64'(v), 64'((exp_ns + 32'd16) % 32'd1_000_000_000));
  endtask

  task automatic t_load_clamp;
    logic [31:0] v;
    load_time(32'hFFFF_FFFF, 16'h0, 32'd0);
    idle(1);
    rd(4'd10, v); check("R6 oversize ns clamped", 64'(v), 999_999_999);
    rd(4'd10, v); check("R5 clamped ns wraps", 64'(v), 3);
    rd(4'd12, v); check("R5 clamped wrap carries", 64'(v), 1);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual 0 expected 1");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    idle(4);
    rst_n = 1'b1;
    idle(1);
    t_reset();
    t_default_period();
    t_wrap();
    t_snapshot();
    t_fraction();
    t_bad_period();
    t_step("positive",   32'd500,         16'h0, 32'd1,  32'd100,               32'd604,         16'h0, 32'd1);
    t_step("borrow",     32'd50,          16'h1, 32'd0,  32'h8000_00C8,         32'd999_999_854, 16'h0, 32'hFFFF_FFFF);
    t_step("carry",      32'd999_999_000, 16'h0, 32'd20, 32'd5000,              32'd4004,        16'h0, 32'd21);
    t_step("clamped",    32'd10,          16'h0, 32'd3,  32'h3FFF_FFFF,         32'd13,          16'h0, 32'd4);
    t_step("double",     32'd999_999_999, 16'h0, 32'd30, 32'd999_999_999,       32'd2,           16'h0, 32'd32);
    t_load_clamp();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule